// File: doc/BRIEF.md
# Three-Wire Synthesizer Programming Port

This block receives configuration words for a dual-channel frequency synthesizer over a slow three-line serial port: a serial clock, a serial data line and a load-enable line. All three lines are treated as asynchronous. Each one is brought into the system clock domain through a synchronizer and a three-sample majority filter. Bits are shifted in, most significant first, on each filtered rising edge of the serial clock. A rising edge on the enable line closes the frame.

The last two bits of a frame are a group code. The group code selects one of four holding registers:

- a control word;
- the channel 1 divide ratio;
- the channel 2 divide ratio;
- the reference divide ratio.

The payload of the frame is taken from the bits just above the group code. Frames may therefore differ in length. Any surplus leading bits are discarded.

Each holding register drives a parallel output and a one-cycle update strobe. Each strobe acts as a valid pulse with no ready. The register keeps its value until the next load of the same group, so the consumer never stalls the port and needs no back-pressure. A sticky flag reports when a channel ratio was loaded before both the reference word and the control word had been loaded since reset.

Top module: `synth_prog_port`

## Requirements
- R1: Serial bits enter most significant bit first, one per filtered rising edge of `ser_clk`. The last bit shifted in is the frame's least significant bit.
- R2: The two last-shifted bits form the group code {second-to-last, last}. The encodings are: 00 = control, 01 = channel 1 ratio, 10 = channel 2 ratio, 11 = reference ratio.
- R3: A channel frame loads the 17 bits immediately preceding the group code into `ch1_ratio` or `ch2_ratio`. Bits shifted in before those 17 are ignored.
- R4: A reference frame loads the 12 bits immediately preceding the group code into `ref_ratio`.
- R5: A control frame loads the 4 bits immediately preceding the group code into `ctrl_word`. Bits [1:0] of `ctrl_word` are the charge-pump current select: 00 = 100 uA, 01 = 200 uA, 10 = 400 uA, 11 = 800 uA.
- R6: A transfer happens only on a filtered rising edge of `ser_en`. Only the register selected by the group code changes.
- R7: The selected register's update strobe is high for exactly one system clock cycle, in the same cycle the new value appears. At most one strobe is high at a time.
- R8: After reset, every holding register is zero, no strobe is high and `order_err` is low.
- R9: If a channel ratio is loaded before both the reference and the control word have been loaded since reset, `order_err` goes high and stays high until reset. The channel write still takes effect.
- R10: When the reference and control words are both loaded before any channel word, `order_err` stays low.
- R11: A pulse on `ser_clk` lasting one system clock cycle is rejected by the majority filter and shifts no bit.
- R12: Serial clock edges that occur while `ser_en` is high shift no bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial bit clock, asynchronous |
| ser_data | input | 1 | Serial data, asynchronous |
| ser_en | input | 1 | Load enable, asynchronous; rising edge transfers the frame |
| ctrl_word | output | 4 | Control register; [1:0] is the charge-pump current select |
| ch1_ratio | output | 17 | Channel 1 divide ratio |
| ch2_ratio | output | 17 | Channel 2 divide ratio |
| ref_ratio | output | 12 | Reference divide ratio |
| ctrl_upd | output | 1 | One-cycle strobe: `ctrl_word` was loaded |
| ch1_upd | output | 1 | One-cycle strobe: `ch1_ratio` was loaded |
| ch2_upd | output | 1 | One-cycle strobe: `ch2_ratio` was loaded |
| ref_upd | output | 1 | One-cycle strobe: `ref_ratio` was loaded |
| order_err | output | 1 | Sticky flag for a programming-order violation |

## Verification
A corrupted shift register shows at the ports one enable edge later: the next frame's payload, or its group steering, comes out wrong. A glitch that slips through the filter, or a shift while enable is high, moves every later bit by one place. Short frames make this visible, because they reuse bits already held in the register. A wrong order-tracking state shows either as `order_err` missing after an early channel load or as `order_err` raised after a correct sequence. Either appears one cycle after the channel strobe. Strobe faults are caught on the cycle they happen: two strobes at once, a strobe longer than one cycle, or a register that changes with no strobe.

// File: rtl/synth_prog_pkg.sv
package synth_prog_pkg;
  localparam int GC_W = 2;

  typedef enum logic [GC_W-1:0] {
    GRP_CTRL = 2'b00,
    GRP_CH1  = 2'b01,
    GRP_CH2  = 2'b10,
    GRP_REF  = 2'b11
  } grp_e;

  function automatic logic maj3(input logic [2:0] s);
    return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
  endfunction
endpackage

// File: rtl/line_filter.sv
module line_filter #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  import synth_prog_pkg::*;

  logic [SYNC_STAGES-1:0] chain;
  logic [2:0]             hist;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
      hist  <= '0;
      dout  <= 1'b0;
    end else begin
      chain <= {chain[SYNC_STAGES-2:0], din};
      hist  <= {hist[1:0], chain[SYNC_STAGES-1]};
      dout  <= maj3(hist);
    end
  end
endmodule

// File: rtl/frame_shifter.sv
module frame_shifter #(
  parameter int SR_W = 19
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            shift,
  input  logic            din,
  output logic [SR_W-1:0] sr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sr <= '0;
    else if (shift) sr <= {sr[SR_W-2:0], din};
  end
endmodule

// File: rtl/reg_bank.sv
module reg_bank #(
  parameter int CH_W   = 17,
  parameter int REF_W  = 12,
  parameter int CTRL_W = 4,
  parameter int SR_W   = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              latch,
  input  logic [SR_W-1:0]   sr,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [CH_W-1:0]   ch1_q,
  output logic [CH_W-1:0]   ch2_q,
  output logic [REF_W-1:0]  ref_q,
  output logic              ctrl_upd,
  output logic              ch1_upd,
  output logic              ch2_upd,
  output logic              ref_upd
);
  import synth_prog_pkg::*;

  grp_e grp;
  assign grp = grp_e'(sr[GC_W-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      ch1_q    <= '0;
      ch2_q    <= '0;
      ref_q    <= '0;
      ctrl_upd <= 1'b0;
      ch1_upd  <= 1'b0;
      ch2_upd  <= 1'b0;
      ref_upd  <= 1'b0;
    end else begin
      ctrl_upd <= 1'b0;
      ch1_upd  <= 1'b0;
      ch2_upd  <= 1'b0;
      ref_upd  <= 1'b0;
      if (latch) begin
        unique case (grp)
          GRP_CTRL: begin
            ctrl_q   <= sr[GC_W+CTRL_W-1:GC_W];
            ctrl_upd <= 1'b1;
          end
          GRP_CH1: begin
            ch1_q   <= sr[GC_W+CH_W-1:GC_W];
            ch1_upd <= 1'b1;
          end
          GRP_CH2: begin
            ch2_q   <= sr[GC_W+CH_W-1:GC_W];
            ch2_upd <= 1'b1;
          end
          GRP_REF: begin
            ref_q   <= sr[GC_W+REF_W-1:GC_W];
            ref_upd <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/order_guard.sv
module order_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic ctrl_upd,
  input  logic ref_upd,
  input  logic ch_upd,
  output logic order_err
);
  logic ctrl_seen, ref_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_seen <= 1'b0;
      ref_seen  <= 1'b0;
      order_err <= 1'b0;
    end else begin
      if (ctrl_upd) ctrl_seen <= 1'b1;
      if (ref_upd)  ref_seen  <= 1'b1;
      if (ch_upd && !(ctrl_seen && ref_seen)) order_err <= 1'b1;
    end
  end
endmodule

// File: rtl/synth_prog_port.sv
module synth_prog_port #(
  parameter int CH_W        = 17,
  parameter int REF_W       = 12,
  parameter int CTRL_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_data,
  input  logic              ser_en,
  output logic [CTRL_W-1:0] ctrl_word,
  output logic [CH_W-1:0]   ch1_ratio,
  output logic [CH_W-1:0]   ch2_ratio,
  output logic [REF_W-1:0]  ref_ratio,
  output logic              ctrl_upd,
  output logic              ch1_upd,
  output logic              ch2_upd,
  output logic              ref_upd,
  output logic              order_err
);
  import synth_prog_pkg::*;

  localparam int SR_W  = CH_W + GC_W;
  localparam int LINES = 3;
  localparam int L_CLK = 0;
  localparam int L_DAT = 1;
  localparam int L_EN  = 2;

  logic [LINES-1:0] raw, filt;
  logic             clk_prev, en_prev;
  logic             clk_rise, en_rise;
  logic [SR_W-1:0]  sr;

  assign raw = {ser_en, ser_data, ser_clk};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    line_filter #(.SYNC_STAGES(SYNC_STAGES)) u_filt (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (raw[g]),
      .dout (filt[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_prev <= 1'b0;
      en_prev  <= 1'b0;
    end else begin
      clk_prev <= filt[L_CLK];
      en_prev  <= filt[L_EN];
    end
  end

  assign clk_rise = filt[L_CLK] & ~clk_prev & ~filt[L_EN];
  assign en_rise  = filt[L_EN] & ~en_prev;

  frame_shifter #(.SR_W(SR_W)) u_shift (
    .clk  (clk),
    .rst_n(rst_n),
    .shift(clk_rise),
    .din  (filt[L_DAT]),
    .sr   (sr)
  );

  reg_bank #(
    .CH_W(CH_W), .REF_W(REF_W), .CTRL_W(CTRL_W), .SR_W(SR_W)
  ) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .latch   (en_rise),
    .sr      (sr),
    .ctrl_q  (ctrl_word),
    .ch1_q   (ch1_ratio),
    .ch2_q   (ch2_ratio),
    .ref_q   (ref_ratio),
    .ctrl_upd(ctrl_upd),
    .ch1_upd (ch1_upd),
    .ch2_upd (ch2_upd),
    .ref_upd (ref_upd)
  );

  order_guard u_order (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctrl_upd (ctrl_upd),
    .ref_upd  (ref_upd),
    .ch_upd   (ch1_upd | ch2_upd),
    .order_err(order_err)
  );
endmodule

// File: rtl/synth_prog_port_chk.sv
module synth_prog_port_chk #(
  parameter int CH_W   = 17,
  parameter int REF_W  = 12,
  parameter int CTRL_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CTRL_W-1:0] ctrl_word,
  input logic [CH_W-1:0]   ch1_ratio,
  input logic [CH_W-1:0]   ch2_ratio,
  input logic [REF_W-1:0]  ref_ratio,
  input logic              ctrl_upd,
  input logic              ch1_upd,
  input logic              ch2_upd,
  input logic              ref_upd,
  input logic              order_err
);
  logic [3:0] upd;
  assign upd = {ctrl_upd, ch1_upd, ch2_upd, ref_upd};

  assert_strobe_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(upd));

  assert_strobe_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (upd != 4'b0) |=> (upd == 4'b0));

  assert_ctrl_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_upd |-> $stable(ctrl_word));

  assert_ch1_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ch1_upd |-> $stable(ch1_ratio));

  assert_ch2_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ch2_upd |-> $stable(ch2_ratio));

  assert_ref_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_upd |-> $stable(ref_ratio));

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    order_err |=> order_err);

  assert_err_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(order_err) |-> $past(ch1_upd || ch2_upd));
endmodule

bind synth_prog_port synth_prog_port_chk #(
  .CH_W(CH_W), .REF_W(REF_W), .CTRL_W(CTRL_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ctrl_word(ctrl_word),
  .ch1_ratio(ch1_ratio),
  .ch2_ratio(ch2_ratio),
  .ref_ratio(ref_ratio),
  .ctrl_upd (ctrl_upd),
  .ch1_upd  (ch1_upd),
  .ch2_upd  (ch2_upd),
  .ref_upd  (ref_upd),
  .order_err(order_err)
);

// File: tb/sim_synth_prog_port.sv
`timescale 1ns/1ps
module sim_synth_prog_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_data = 1'b0, ser_en = 1'b0;
  logic [3:0]  ctrl_word;
  logic [16:0] ch1_ratio, ch2_ratio;
  logic [11:0] ref_ratio;
  logic ctrl_upd, ch1_upd, ch2_upd, ref_upd, order_err;

  int checks = 0, errors = 0;
  int n_ctrl = 0, n_ch1 = 0, n_ch2 = 0, n_ref = 0, n_wide = 0, n_multi = 0;
  logic [3:0] prev_upd = '0;
  bit done = 0;

  always #10 clk = ~clk;

  synth_prog_port u0 (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data), .ser_en(ser_en),
    .ctrl_word(ctrl_word), .ch1_ratio(ch1_ratio), .ch2_ratio(ch2_ratio), .ref_ratio(ref_ratio),
    .ctrl_upd(ctrl_upd), .ch1_upd(ch1_upd), .ch2_upd(ch2_upd), .ref_upd(ref_upd),
    .order_err(order_err)
  );

  always @(negedge clk) begin
    logic [3:0] u;
    u = {ctrl_upd, ch1_upd, ch2_upd, ref_upd};
    if (rst_n) begin
      n_ctrl += int'(ctrl_upd);
      n_ch1  += int'(ch1_upd);
      n_ch2  += int'(ch2_upd);
      n_ref  += int'(ref_upd);
      if ((u & prev_upd) != 4'b0) n_wide++;
      if ($countones(u) > 1) n_multi++;
    end
    prev_upd = u;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 1'b0;
    ser_clk = 1'b0; ser_data = 1'b0; ser_en = 1'b0;
    wait_n(4);
    rst_n = 1'b1;
    wait_n(8);
    n_ctrl = 0; n_ch1 = 0; n_ch2 = 0; n_ref = 0;
  endtask

  task automatic clock_bit(input logic b);
    ser_data = b;
    wait_n(6);
    ser_clk = 1'b1;
    wait_n(6);
    ser_clk = 1'b0;
    wait_n(6);
  endtask

  task automatic latch_pulse();
    ser_en = 1'b1;
    wait_n(10);
    ser_en = 1'b0;
    wait_n(10);
  endtask

  // sends bits[len-1] first; a glitch index >= 0 adds a one-cycle clock pulse after that bit
  task automatic send_frame(input logic [31:0] bits, input int len, input int glitch_at);
    for (int i = len - 1; i >= 0; i--) begin
      clock_bit(bits[i]);
      if (glitch_at == i) begin
        ser_data = 1'b1;
        wait_n(3);
        ser_clk = 1'b1;
        wait_n(1);
        ser_clk = 1'b0;
        wait_n(6);
      end
    end
    latch_pulse();
  endtask

  task automatic t_reset();
    apply_reset();
    chk("R8 ctrl_word", 32'(ctrl_word), 0);
    chk("R8 ch1_ratio", 32'(ch1_ratio), 0);
    chk("R8 ch2_ratio", 32'(ch2_ratio), 0);
    chk("R8 ref_ratio", 32'(ref_ratio), 0);
    chk("R8 strobes", 32'({ctrl_upd, ch1_upd, ch2_upd, ref_upd}), 0);
    chk("R8 order_err", 32'(order_err), 0);
  endtask

  task automatic t_early_channel();
    apply_reset();
    send_frame({17'h1ABCD, 2'b01}, 19, -1);
    chk("R9 write completes", 32'(ch1_ratio), 32'h1ABCD);
    chk("R9 order_err set", 32'(order_err), 1);
    chk("R7 ch1 strobe count", n_ch1, 1);
    send_frame({12'h123, 2'b11}, 14, -1);
    send_frame({4'h3, 2'b00}, 6, -1);
    chk("R9 order_err sticky", 32'(order_err), 1);
  endtask

  task automatic t_setup();
    apply_reset();
    send_frame({12'hA5C, 2'b11}, 14, -1);
    chk("R4 ref_ratio", 32'(ref_ratio), 32'hA5C);
    chk("R7 ref strobe count", n_ref, 1);
    chk("R6 ctrl untouched", 32'(ctrl_word), 0);
    send_frame({4'hA, 2'b00}, 6, -1);
    chk("R2 ctrl_word", 32'(ctrl_word), 32'hA);
    chk("R5 pump select 10=400uA", 32'(ctrl_word[1:0]), 32'h2);
    chk("R6 ref untouched", 32'(ref_ratio), 32'hA5C);
    chk("R7 ctrl strobe count", n_ctrl, 1);
  endtask

  task automatic t_channels();
    send_frame({17'h15555, 2'b01}, 19, -1);
    chk("R1 ch1_ratio", 32'(ch1_ratio), 32'h15555);
    send_frame({17'h0F0F1, 2'b10}, 19, -1);
    chk("R3 ch2_ratio", 32'(ch2_ratio), 32'h0F0F1);
    chk("R6 ch1 untouched", 32'(ch1_ratio), 32'h15555);
    chk("R10 order_err clear", 32'(order_err), 0);
    chk("R7 ch strobe counts", 32'({n_ch1[15:0], n_ch2[15:0]}), 32'h0001_0001);
  endtask

  task automatic t_long_frame();
    send_frame({4'hF, 17'h00003, 2'b10}, 23, -1);
    chk("R3 surplus bits ignored", 32'(ch2_ratio), 32'h3);
  endtask

  task automatic t_glitch();
    send_frame({17'h0C3A5, 2'b01}, 19, 9);
    chk("R11 glitch rejected", 32'(ch1_ratio), 32'h0C3A5);
  endtask

  task automatic t_en_high_clock();
    send_frame({4'h6, 2'b00}, 6, -1);
    chk("R5 ctrl reload", 32'(ctrl_word), 32'h6);
    ser_en = 1'b1;
    wait_n(10);
    for (int k = 0; k < 3; k++) clock_bit(1'b1);
    ser_en = 1'b0;
    wait_n(10);
    // only the group code is sent; payload comes from bits already held
    send_frame({2'b00}, 2, -1);
    chk("R12 no shift while enable high", 32'(ctrl_word), 32'h8);
  endtask

  initial begin
    t_reset();
    t_early_channel();
    t_setup();
    t_channels();
    t_long_frame();
    t_glitch();
    t_en_high_clock();
    chk("R7 no long strobe", n_wide, 0);
    chk("R7 no simultaneous strobes", n_multi, 0);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule